// File: doc/BRIEF.md
# Serial Program-Memory Write Engine with Read-Back Confirmation

This block drives a byte-serial programming link to a target microcontroller. It accepts one command at a time. The command set is: read a program-memory byte, write a program-memory byte, commit a program-memory page, read a data-EEPROM byte and write a data-EEPROM byte. Each command goes out as a frame of four bytes over a request/acknowledge byte-exchange port. The response to the fourth byte carries the read result.

After a program-memory write or a page commit, the engine confirms that the target has finished. There are two ways to do this. The first is a fixed wait measured in timer units. The second is polling: the engine reads the same address again and again until the returned value differs from a busy sentinel. Polling gives up after a set number of retry slots and reports an error. When the value just written equals the sentinel, polling cannot tell "busy" from "done", so the engine uses the fixed wait instead. A data-EEPROM write always ends with a longer fixed wait. Every command ends with a single-cycle done pulse or a single-cycle error pulse.

Top module: `isp_flash_engine`

## Requirements
- R1: Op code 0 (program read) sends four bytes in this order: 0x20 with bit 3 equal to address bit 0, then address bits 16:9, then address bits 8:1, then 0x00. The response to the fourth byte appears on `rd_data` when `done` pulses.
- R2: Op code 1 (program write) sends four bytes: 0x40 with bit 3 equal to address bit 0, then address bits 16:9, then address bits 8:1, then the data byte.
- R3: When polling is disabled, a program write pulses `done` after its fourth byte and sends no further bytes.
- R4: A program write with polling enabled and data equal to 0x7F sends no read frames. `done` pulses WR_WAIT_UNITS×UNIT_CYCLES cycles (within a few cycles) after the last byte is acknowledged.
- R5: A program write with polling enabled and any other data sends program-read frames (R1 format) for the same address until a response differs from 0x7F, then pulses `done`.
- R6: If every poll response equals the sentinel, `error` pulses (and `done` does not) at the first read completion after RETRY_SLOTS slots of SLOT_CYCLES cycles have elapsed.
- R7: Op code 2 (page commit) sends 0x4C, address bits 16:9, address bits 8:1 and 0x00. If the poll value is 0xFF it then waits WR_WAIT_UNITS×UNIT_CYCLES cycles. Otherwise it polls with program reads until a response differs from 0xFF.
- R8: Op code 3 (EEPROM read) sends 0xA0, address bits 15:8, address bits 7:0 and 0x00, and returns the fourth response on `rd_data`.
- R9: Op code 4 (EEPROM write) sends 0xC0, address bits 15:8, address bits 7:0 and the data byte. It then waits EE_WAIT_UNITS×UNIT_CYCLES cycles before `done`.
- R10: `cmd_ready` is low from acceptance until the cycle in which `done` or `error` pulses. A `cmd_valid` asserted while `cmd_ready` is low is ignored. `done` and `error` last one cycle and are never high together.
- R11: After reset, `cmd_ready` is high and `xfer_req`, `done` and `error` are low.
- R12: Op codes 5 to 7 are rejected: `error` pulses and no byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 3 | Operation code (R1, R2, R7, R8, R9, R12) |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_data | input | 8 | Data byte to write |
| cmd_poll_en | input | 1 | Enable completion confirmation for program writes |
| cmd_poll_val | input | 8 | Page-commit poll value |
| xfer_req | output | 1 | Byte exchange request, held until acknowledged |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Byte exchange complete, one cycle |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |
| done | output | 1 | Command completed, one cycle |
| error | output | 1 | Command failed, one cycle |
| rd_data | output | 8 | Last read result |

## Verification
The bench sweeps read frames over spread-out addresses, including 0, odd addresses and the top of the range. This separates the placement of address bit 0 in the op byte from the two address bytes. Program writes are tried three ways: without polling, with the sentinel value, and with other data while the target model stays busy for 0 to 3 reads. These cases separate the no-confirmation, fixed-wait and polling paths by the number of frames sent and by the latency to `done`. A target that never leaves the busy state checks the retry timeout. Page commits with both poll values, EEPROM accesses, a request made while busy and illegal op codes cover the remaining paths.

// File: rtl/isp_cmd_pkg.sv
package isp_cmd_pkg;

   typedef enum logic [2:0] {
      OP_FREAD  = 3'd0,
      OP_FWRITE = 3'd1,
      OP_FLUSH  = 3'd2,
      OP_EREAD  = 3'd3,
      OP_EWRITE = 3'd4
   } isp_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FRAME,
      ST_FIX,
      ST_POLL
   } eng_state_e;

   localparam logic [7:0] CODE_FREAD  = 8'h20;
   localparam logic [7:0] CODE_FWRITE = 8'h40;
   localparam logic [7:0] CODE_FLUSH  = 8'h4C;
   localparam logic [7:0] CODE_EREAD  = 8'hA0;
   localparam logic [7:0] CODE_EWRITE = 8'hC0;

   localparam logic [7:0] WRITE_SENTINEL = 8'h7F;
   localparam logic [7:0] FLUSH_SENTINEL = 8'hFF;

endpackage

// File: rtl/isp_frame_build.sv
module isp_frame_build
   import isp_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
) (
   input  logic [2:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   input  logic [1:0]        idx,
   output logic [7:0]        tx_byte
);

   logic [7:0] b0, b1, b2, b3;
   logic [7:0] lo_sel;

   assign lo_sel = {4'b0000, addr[0], 3'b000};

   always_comb begin
      b0 = 8'h00;
      b1 = addr[16:9];
      b2 = addr[8:1];
      b3 = 8'h00;
      case (op)
         OP_FREAD:  b0 = CODE_FREAD | lo_sel;
         OP_FWRITE: begin
            b0 = CODE_FWRITE | lo_sel;
            b3 = data;
         end
         OP_FLUSH:  b0 = CODE_FLUSH;
         OP_EREAD:  begin
            b0 = CODE_EREAD;
            b1 = addr[15:8];
            b2 = addr[7:0];
         end
         OP_EWRITE: begin
            b0 = CODE_EWRITE;
            b1 = addr[15:8];
            b2 = addr[7:0];
            b3 = data;
         end
         default:   b0 = 8'h00;
      endcase
   end

   always_comb begin
      case (idx)
         2'd0:    tx_byte = b0;
         2'd1:    tx_byte = b1;
         2'd2:    tx_byte = b2;
         default: tx_byte = b3;
      endcase
   end

endmodule

// File: rtl/isp_byte_seq.sv
module isp_byte_seq #(
   parameter int unsigned FRAME_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       xfer_ack,
   input  logic [7:0] xfer_rx,
   output logic       xfer_req,
   output logic [1:0] idx,
   output logic       fin,
   output logic [7:0] last_rx
);

   localparam logic [1:0] LAST_IDX = 2'(FRAME_LEN - 1);

   logic active;

   initial begin
      assert (FRAME_LEN >= 2 && FRAME_LEN <= 4)
         else $error("isp_byte_seq: FRAME_LEN must be 2..4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         idx     <= 2'd0;
         fin     <= 1'b0;
         last_rx <= 8'h00;
      end else begin
         fin <= 1'b0;
         if (!active) begin
            if (start) begin
               active <= 1'b1;
               idx    <= 2'd0;
            end
         end else if (xfer_ack) begin
            if (idx == LAST_IDX) begin
               active  <= 1'b0;
               fin     <= 1'b1;
               last_rx <= xfer_rx;
            end else begin
               idx <= idx + 2'd1;
            end
         end
      end
   end

   assign xfer_req = active;

   // R1: a pending request stays up with a steady byte until acknowledged
   assert_req_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_ack) |=> (xfer_req && $stable(idx)));

endmodule

// File: rtl/isp_tick_timer.sv
module isp_tick_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [CNT_W-1:0] period,
   output logic             tick
);

   logic [CNT_W-1:0] cnt;

   initial begin
      assert (CNT_W >= 1) else $error("isp_tick_timer: CNT_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= period - CNT_W'(1);
      else if (en)
         cnt <= (cnt == '0) ? period - CNT_W'(1) : cnt - CNT_W'(1);
   end

   assign tick = en && !clear && (cnt == '0);

endmodule

// File: rtl/isp_flash_engine.sv
module isp_flash_engine
   import isp_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W        = 17,
   parameter int unsigned UNIT_CYCLES   = 64,
   parameter int unsigned WR_WAIT_UNITS = 15,
   parameter int unsigned EE_WAIT_UNITS = 30,
   parameter int unsigned SLOT_CYCLES   = 64,
   parameter int unsigned RETRY_SLOTS   = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              cmd_poll_en,
   input  logic [7:0]        cmd_poll_val,
   output logic              xfer_req,
   output logic [7:0]        xfer_tx,
   input  logic              xfer_ack,
   input  logic [7:0]        xfer_rx,
   output logic              done,
   output logic              error,
   output logic [7:0]        rd_data
);

   localparam int unsigned WR_LEN  = WR_WAIT_UNITS * UNIT_CYCLES;
   localparam int unsigned EE_LEN  = EE_WAIT_UNITS * UNIT_CYCLES;
   localparam int unsigned FIX_MAX = (WR_LEN > EE_LEN) ? WR_LEN : EE_LEN;
   localparam int unsigned CNT_MAX = (FIX_MAX > SLOT_CYCLES) ? FIX_MAX : SLOT_CYCLES;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam int unsigned RTY_W   = $clog2(RETRY_SLOTS + 1);

   initial begin
      assert (ADDR_W >= 17) else $error("isp_flash_engine: ADDR_W must be >= 17");
      assert (UNIT_CYCLES >= 1 && SLOT_CYCLES >= 1)
         else $error("isp_flash_engine: timer periods must be positive");
      assert (WR_WAIT_UNITS >= 1 && EE_WAIT_UNITS >= 1 && RETRY_SLOTS >= 1)
         else $error("isp_flash_engine: wait and retry counts must be positive");
   end

   eng_state_e        state;
   logic [2:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic [7:0]        sentinel_q;
   logic [RTY_W-1:0]  retries_q;
   logic              seq_go;
   logic              done_q, err_q;
   logic [7:0]        rd_q;

   logic [2:0]        frame_op;
   logic [1:0]        seq_idx;
   logic              seq_fin;
   logic [7:0]        seq_rx;
   logic [CNT_W-1:0]  fix_len;
   logic              fix_tick, slot_tick;
   logic              op_legal;

   assign frame_op = (state == ST_POLL) ? 3'(OP_FREAD) : op_q;
   assign fix_len  = (op_q == 3'(OP_EWRITE)) ? CNT_W'(EE_LEN) : CNT_W'(WR_LEN);
   assign op_legal = (cmd_op <= 3'(OP_EWRITE));

   isp_frame_build #(.ADDR_W(ADDR_W)) u_frame (
      .op      (frame_op),
      .addr    (addr_q),
      .data    (data_q),
      .idx     (seq_idx),
      .tx_byte (xfer_tx)
   );

   isp_byte_seq #(.FRAME_LEN(4)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (seq_go),
      .xfer_ack (xfer_ack),
      .xfer_rx  (xfer_rx),
      .xfer_req (xfer_req),
      .idx      (seq_idx),
      .fin      (seq_fin),
      .last_rx  (seq_rx)
   );

   isp_tick_timer #(.CNT_W(CNT_W)) u_fix_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state != ST_FIX),
      .en     (state == ST_FIX),
      .period (fix_len),
      .tick   (fix_tick)
   );

   isp_tick_timer #(.CNT_W(CNT_W)) u_slot_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (state != ST_POLL),
      .en     (state == ST_POLL),
      .period (CNT_W'(SLOT_CYCLES)),
      .tick   (slot_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         op_q       <= 3'd0;
         addr_q     <= '0;
         data_q     <= 8'h00;
         sentinel_q <= 8'h00;
         retries_q  <= '0;
         seq_go     <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         rd_q       <= 8'h00;
      end else begin
         seq_go <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  if (op_legal) begin
                     op_q     <= cmd_op;
                     addr_q   <= cmd_addr;
                     data_q   <= cmd_data;
                     state    <= ST_FRAME;
                     seq_go   <= 1'b1;
                     retries_q <= RTY_W'(RETRY_SLOTS);
                     if (cmd_op == 3'(OP_FLUSH))
                        sentinel_q <= FLUSH_SENTINEL;
                     else
                        sentinel_q <= WRITE_SENTINEL;
                     // a write only confirms when polling is on; a commit always does
                     if (cmd_op == 3'(OP_FWRITE) && !cmd_poll_en)
                        sentinel_q <= 8'h00;
                     if (cmd_op == 3'(OP_FWRITE) && cmd_poll_en && cmd_data == WRITE_SENTINEL)
                        sentinel_q <= 8'h01;
                     if (cmd_op == 3'(OP_FLUSH) && cmd_poll_val == FLUSH_SENTINEL)
                        sentinel_q <= 8'h01;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_FRAME: begin
               if (seq_fin) begin
                  case (op_q)
                     3'(OP_FREAD), 3'(OP_EREAD): begin
                        rd_q   <= seq_rx;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                     end
                     3'(OP_EWRITE): state <= ST_FIX;
                     default: begin
                        if (sentinel_q == 8'h00) begin
                           done_q <= 1'b1;
                           state  <= ST_IDLE;
                        end else if (sentinel_q == 8'h01) begin
                           state <= ST_FIX;
                        end else begin
                           state  <= ST_POLL;
                           seq_go <= 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_FIX: begin
               if (fix_tick) begin
                  done_q <= 1'b1;
                  state  <= ST_IDLE;
               end
            end
            ST_POLL: begin
               if (slot_tick && retries_q != '0)
                  retries_q <= retries_q - RTY_W'(1);
               if (seq_fin) begin
                  if (seq_rx != sentinel_q) begin
                     done_q <= 1'b1;
                     state  <= ST_IDLE;
                  end else if (retries_q == '0) begin
                     err_q <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     seq_go <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state == ST_IDLE);
   assign done      = done_q;
   assign error     = err_q;
   assign rd_data   = rd_q;

   // R10: completion pulses are exclusive and land with the engine idle again
   assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && error));
   assert_pulse_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done || error) |-> cmd_ready);
   // R6: the retry budget never exceeds its load value
   assert_retry_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      retries_q <= RTY_W'(RETRY_SLOTS));
   // R6 / R12: an error comes only from a poll or a rejected op code
   assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> ($past(state) == ST_POLL || $past(cmd_valid && cmd_ready)));
   // R4: no bytes move during a fixed wait
   assert_fix_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FIX) |-> !xfer_req);

endmodule

// File: tb/isp_flash_engine_bench.sv
module isp_flash_engine_bench;

   localparam int UC   = 4;
   localparam int WRU  = 15;
   localparam int EEU  = 30;
   localparam int SLOT = 30;
   localparam int RS   = 30;
   localparam int WRP  = WRU * UC;
   localparam int EEP  = EEU * UC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_op = 3'd0;
   logic [16:0] cmd_addr = '0;
   logic [7:0]  cmd_data = 8'h00;
   logic        cmd_poll_en = 1'b0;
   logic [7:0]  cmd_poll_val = 8'h00;
   logic        xfer_req;
   logic [7:0]  xfer_tx;
   logic        xfer_ack = 1'b0;
   logic [7:0]  xfer_rx = 8'h00;
   logic        done, error;
   logic [7:0]  rd_data;

   always #5 clk = ~clk;

   isp_flash_engine #(
      .ADDR_W(17), .UNIT_CYCLES(UC), .WR_WAIT_UNITS(WRU),
      .EE_WAIT_UNITS(EEU), .SLOT_CYCLES(SLOT), .RETRY_SLOTS(RS)
   ) u_isp_flash_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .cmd_poll_en(cmd_poll_en), .cmd_poll_val(cmd_poll_val),
      .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .done(done), .error(error), .rd_data(rd_data)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int tests = 0;
   int fails = 0;

   // target model
   logic [7:0] tx_log [0:1023];
   int   log_n = 0;
   int   pos = 0;
   logic [7:0] cur_op = 8'h00;
   int   reads_n = 0;
   int   busy_left = 0;
   logic [7:0] busy_val = 8'h7F;
   logic [7:0] final_val = 8'h00;
   int   last_ack_cyc = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         xfer_ack = 1'b0;
      end else if (xfer_ack) begin
         xfer_ack = 1'b0;
      end else if (xfer_req) begin
         if (log_n < 1024) tx_log[log_n] = xfer_tx;
         log_n = log_n + 1;
         if (pos == 0) cur_op = xfer_tx;
         xfer_rx = 8'h5A;
         if (pos == 3 && (((cur_op & 8'hF7) == 8'h20) || cur_op == 8'hA0)) begin
            reads_n = reads_n + 1;
            if (busy_left > 0) begin
               xfer_rx = busy_val;
               busy_left = busy_left - 1;
            end else begin
               xfer_rx = final_val;
            end
         end
         pos = (pos + 1) % 4;
         xfer_ack = 1'b1;
         last_ack_cyc = cyc;
      end
   end

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic issue(input logic [2:0] op, input logic [16:0] addr, input logic [7:0] data,
                        input bit pen, input logic [7:0] pval,
                        output int base, output int lat_ack, output int lat_cmd,
                        output bit got_done, output bit got_err);
      int start_c;
      int n;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      base = log_n;
      reads_n = 0;
      cmd_op = op; cmd_addr = addr; cmd_data = data;
      cmd_poll_en = pen; cmd_poll_val = pval;
      cmd_valid = 1'b1;
      start_c = cyc;
      @(negedge clk);
      cmd_valid = 1'b0;
      got_done = 0; got_err = 0; n = 0;
      while (!(done || error) && n < 5000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 5000) check(0, "watchdog", n, 0);
      got_done = done; got_err = error;
      lat_ack = cyc - last_ack_cyc;
      lat_cmd = cyc - start_c;
   endtask

   function automatic logic [31:0] frame_at(int b);
      return {tx_log[b], tx_log[b+1], tx_log[b+2], tx_log[b+3]};
   endfunction

   function automatic logic [31:0] pfrm(logic [7:0] code, logic [16:0] a, logic [7:0] last);
      return {code | {4'b0, a[0], 3'b0}, a[16:9], a[8:1], last};
   endfunction

   initial begin
      #(200000 * 10);
      check(0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      int base, la, lc;
      bit gd, ge;
      logic [16:0] a;

      repeat (3) @(negedge clk);
      // R11: reset state
      check(cmd_ready === 1'b1, "R11 ready", cmd_ready, 1);
      check(xfer_req === 1'b0 && done === 1'b0 && error === 1'b0, "R11 outputs",
            {xfer_req, done, error}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: program read sweep
      for (int i = 0; i < 18; i++) begin
         a = (i == 16) ? 17'h1FFFF : (i == 17) ? 17'h0 : 17'((i * 32'h2A3B + i) & 32'h1FFFF);
         busy_left = 0;
         final_val = 8'(i * 7 + 3);
         issue(3'd0, a, 8'h00, 0, 8'h00, base, la, lc, gd, ge);
         check(frame_at(base) == pfrm(8'h20, a, 8'h00), "R1 frame", frame_at(base), pfrm(8'h20, a, 8'h00));
         check(gd && !ge && rd_data == final_val, "R1 data", rd_data, final_val);
      end

      // R2 / R3: write without polling
      for (int i = 0; i < 6; i++) begin
         a = 17'(i * 32'h5555 + 1);
         issue(3'd1, a, 8'(i * 40 + 1), 0, 8'h00, base, la, lc, gd, ge);
         check(frame_at(base) == pfrm(8'h40, a, 8'(i * 40 + 1)), "R2 frame",
               frame_at(base), pfrm(8'h40, a, 8'(i * 40 + 1)));
         check(gd && (log_n - base) == 4 && reads_n == 0, "R3 no confirm", log_n - base, 4);
      end

      // R4: sentinel data takes the fixed wait
      a = 17'h0ABCD;
      issue(3'd1, a, 8'h7F, 1, 8'h00, base, la, lc, gd, ge);
      check(gd && (log_n - base) == 4, "R4 no reads", log_n - base, 4);
      check(la >= WRP && la <= WRP + 4, "R4 wait", la, WRP);

      // R5: polling until non-sentinel
      for (int k = 0; k < 4; k++) begin
         a = 17'(17'h10F0F + k);
         busy_left = k; busy_val = 8'h7F; final_val = 8'h3C;
         issue(3'd1, a, 8'h3C, 1, 8'h00, base, la, lc, gd, ge);
         check(gd && !ge && reads_n == k + 1, "R5 read count", reads_n, k + 1);
         check((log_n - base) == 4 + 4 * (k + 1), "R5 bytes", log_n - base, 4 + 4 * (k + 1));
         check(frame_at(log_n - 4) == pfrm(8'h20, a, 8'h00), "R5 poll frame",
               frame_at(log_n - 4), pfrm(8'h20, a, 8'h00));
      end

      // R6: timeout
      busy_left = 100000; busy_val = 8'h7F;
      issue(3'd1, 17'h00123, 8'h11, 1, 8'h00, base, la, lc, gd, ge);
      check(ge && !gd, "R6 error", {gd, ge}, 1);
      check(lc >= RS * SLOT && lc <= RS * SLOT + 40, "R6 timeout", lc, RS * SLOT);
      busy_left = 0;

      // R7: page commit, fixed and polled
      a = 17'h1B2C3;
      issue(3'd2, a, 8'h00, 0, 8'hFF, base, la, lc, gd, ge);
      check(frame_at(base) == {8'h4C, a[16:9], a[8:1], 8'h00}, "R7 frame",
            frame_at(base), {8'h4C, a[16:9], a[8:1], 8'h00});
      check(gd && (log_n - base) == 4 && la >= WRP && la <= WRP + 4, "R7 fixed wait", la, WRP);
      busy_left = 2; busy_val = 8'hFF; final_val = 8'h00;
      issue(3'd2, a, 8'h00, 0, 8'h00, base, la, lc, gd, ge);
      check(gd && reads_n == 3, "R7 poll count", reads_n, 3);

      // R8: EEPROM read
      for (int i = 0; i < 4; i++) begin
         a = 17'(i * 32'h3C5A + 32'h0081);
         final_val = 8'(8'hE0 + i);
         issue(3'd3, a, 8'h00, 0, 8'h00, base, la, lc, gd, ge);
         check(frame_at(base) == {8'hA0, a[15:8], a[7:0], 8'h00}, "R8 frame",
               frame_at(base), {8'hA0, a[15:8], a[7:0], 8'h00});
         check(gd && rd_data == final_val, "R8 data", rd_data, final_val);
      end

      // R9 / R10: EEPROM write, with an extra request while busy
      a = 17'h0F00D;
      @(negedge clk);
      base = log_n;
      cmd_op = 3'd4; cmd_addr = a; cmd_data = 8'h96; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(cmd_ready == 1'b0, "R10 busy", cmd_ready, 0);
      cmd_op = 3'd3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!(done || error)) @(negedge clk);
      la = cyc - last_ack_cyc;
      check(frame_at(base) == {8'hC0, a[15:8], a[7:0], 8'h96}, "R9 frame",
            frame_at(base), {8'hC0, a[15:8], a[7:0], 8'h96});
      check(done && la >= EEP && la <= EEP + 4, "R9 wait", la, EEP);
      @(negedge clk);
      check(done == 1'b0 && error == 1'b0, "R10 single pulse", done, 0);
      repeat (20) @(negedge clk);
      check((log_n - base) == 4 && cmd_ready, "R10 ignored request", log_n - base, 4);

      // R12: illegal op codes
      for (int o = 5; o < 8; o++) begin
         issue(3'(o), 17'h1, 8'h00, 0, 8'h00, base, la, lc, gd, ge);
         check(ge && !gd && (log_n - base) == 0, "R12 reject", log_n - base, 0);
      end

      finish_run();
   end

endmodule